// File: doc/BRIEF.md
# Dual-Bank SDRAM Refresh Scheduler with Lateness Monitor

This block decides when each of two SDRAM banks owes a refresh. It does not issue the refresh itself. An interval timer runs on the memory clock. Each time the timer completes a programmed period, one refresh obligation is added to the backlog of every enabled bank. The memory controller sees a per-bank request while that bank's backlog is non-zero. Each grant it returns through the acknowledge input retires one owed refresh.

Software sets the timer period, a coarse frequency divider and a lateness budget through a small register bus. When a bank's backlog grows beyond the budget, a sticky error flag rises for that bank. The flag stays up until software clears it. The configuration word also carries per-bank enable bits and device-size bits. It has self-clearing manual-access bits that strobe the pin-value path of a disabled bank.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset the configuration word (offset 0x00) reads 0x0000, the interval (offset 0x02) reads 0x0400, the lateness limit (offset 0x04) reads 0x0200 and the error status (offset 0x06) reads 0x0000. All requests, enables, manual pulses and error flags are low.
- R2: In the configuration word, bits 1:0 are the enables for bank A and bank B, bits 5:4 are the size bits for A and B (0 = 8 MB, 1 = 16 MB, driven on `bank_size`), and bits 7:6 are the frequency code. Bits 3:2 (manual) and 15:8 always read zero.
- R3: A write to offset 0x00 that sets bit 2 (bank A) or bit 3 (bank B), while the same write leaves that bank's enable bit at 0, raises that bank's `man_pulse` bit for exactly the cycle after the write edge. If the written enable bit is 1, no pulse is raised.
- R4: A register write takes effect at the clock edge where `bus_we` is high. `bus_rdata` shows the register selected by `bus_addr` one clock edge after the address is presented.
- R5: One refresh obligation occurs every N×F memory-clock cycles. N is the interval value. F is 16, 8, 4 or 4 for frequency codes 00, 01, 10 or 11. A write to the interval register restarts the timer, so the first obligation counts at the N×F-th edge after that write edge.
- R6: `ref_req[b]` is high exactly when bank b is enabled and its backlog is non-zero. It rises right after the edge at which the obligation is counted.
- R7: Each edge with `ref_ack[b]` high and a non-zero backlog retires one refresh. The request drops right after the acknowledge edge that empties the backlog. An acknowledge with an empty backlog is ignored.
- R8: A backlog holds at its maximum of 2^BACKLOG_W − 1 instead of wrapping.
- R9: Disabling a bank clears its backlog and drops its request. Re-enabling it starts from an empty backlog.
- R10: `late_err[b]` rises one edge after bank b's backlog first exceeds the limit, and stays set. Writing 1 to bit b of offset 0x06 clears it, unless the backlog is still over the limit. Bits 1:0 of offset 0x06 read the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data |
| ref_ack | input | 2 | Per-bank refresh grant from the controller |
| ref_req | output | 2 | Per-bank refresh request |
| bank_en | output | 2 | Per-bank enable as programmed |
| bank_size | output | 2 | Per-bank device size bit |
| man_pulse | output | 2 | Per-bank manual pin-access strobe |
| late_err | output | 2 | Per-bank sticky lateness error |

## Verification
Every result has a fixed delay, counted from the clock edge that carries the stimulus. Read data appears one edge after the address. A manual strobe is visible only in the cycle right after its write edge. The first request appears exactly N×F edges after the interval write edge. A request falls right after the emptying acknowledge. An error flag rises one edge after the backlog crosses the limit. The bench drives on falling edges and counts whole cycles from the write that starts each case. It samples on the falling edge one cycle before and exactly at the due edge, so an off-by-one in either direction is caught. Saturation is seen only through the number of acknowledges needed before the request drops.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

   localparam int NUM_BANKS = 2;

   localparam int OFS_CONF  = 'h00;
   localparam int OFS_INTV  = 'h02;
   localparam int OFS_LIMIT = 'h04;
   localparam int OFS_STAT  = 'h06;

   typedef enum logic [1:0] {
      FREQ_DIV16 = 2'b00,
      FREQ_DIV8  = 2'b01,
      FREQ_DIV4  = 2'b10,
      FREQ_SPARE = 2'b11
   } freq_code_e;

   // stored part of the configuration word
   typedef struct packed {
      logic [1:0] freq;
      logic [1:0] size;
      logic [1:0] enable;
   } conf_t;

   // last value of the unit prescaler for a frequency code
   function automatic logic [3:0] units_last(input logic [1:0] code);
      case (freq_code_e'(code))
         FREQ_DIV16: return 4'd15;
         FREQ_DIV8:  return 4'd7;
         default:    return 4'd3;
      endcase
   endfunction

endpackage

// File: rtl/refresh_regs.sv
module refresh_regs
   import sdram_refresh_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 16,
   parameter int LIMIT_W   = 16,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 we,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_BANKS-1:0] err_flags,
   output logic [DATA_W-1:0]    rdata,
   output logic [NUM_BANKS-1:0] enable,
   output logic [NUM_BANKS-1:0] size,
   output logic [1:0]           freq,
   output logic [CNT_W-1:0]     interval,
   output logic [LIMIT_W-1:0]   limit,
   output logic                 restart,
   output logic [NUM_BANKS-1:0] man_pulse,
   output logic [NUM_BANKS-1:0] err_clr
);

   localparam logic [CNT_W-1:0]   INTV_RST  = CNT_W'(16'h0400);
   localparam logic [LIMIT_W-1:0] LIMIT_RST = LIMIT_W'(16'h0200);

   conf_t                conf_q;
   logic [CNT_W-1:0]     intv_q;
   logic [LIMIT_W-1:0]   limit_q;
   logic [NUM_BANKS-1:0] man_q;
   logic                 wr_conf, wr_intv, wr_limit, wr_stat;
   logic [DATA_W-1:0]    rd_next;

   assign wr_conf  = we && (addr == ADDR_W'(OFS_CONF));
   assign wr_intv  = we && (addr == ADDR_W'(OFS_INTV));
   assign wr_limit = we && (addr == ADDR_W'(OFS_LIMIT));
   assign wr_stat  = we && (addr == ADDR_W'(OFS_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conf_q  <= '0;
         intv_q  <= INTV_RST;
         limit_q <= LIMIT_RST;
         man_q   <= '0;
      end else begin
         man_q <= '0;
         if (wr_conf) begin
            conf_q.enable <= wdata[1:0];
            conf_q.size   <= wdata[5:4];
            conf_q.freq   <= wdata[7:6];
            man_q         <= wdata[3:2] & ~wdata[1:0];
         end
         if (wr_intv)  intv_q  <= wdata[CNT_W-1:0];
         if (wr_limit) limit_q <= wdata[LIMIT_W-1:0];
      end
   end

   always_comb begin
      rd_next = '0;
      case (addr)
         ADDR_W'(OFS_CONF):  rd_next[7:0] = {conf_q.freq, conf_q.size, 2'b00, conf_q.enable};
         ADDR_W'(OFS_INTV):  rd_next = DATA_W'(intv_q);
         ADDR_W'(OFS_LIMIT): rd_next = DATA_W'(limit_q);
         ADDR_W'(OFS_STAT):  rd_next[NUM_BANKS-1:0] = err_flags;
         default:            rd_next = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_next;
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_next;
      end
   endgenerate

   assign enable    = conf_q.enable;
   assign size      = conf_q.size;
   assign freq      = conf_q.freq;
   assign interval  = intv_q;
   assign limit     = limit_q;
   assign restart   = wr_intv;
   assign man_pulse = man_q;
   assign err_clr   = wr_stat ? wdata[NUM_BANKS-1:0] : '0;

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
   import sdram_refresh_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] interval,
   input  logic [1:0]       freq,
   output logic             tick
);

   logic [CNT_W-1:0] cnt_q;
   logic [3:0]       unit_q;
   logic [CNT_W:0]   cnt_inc;
   logic             period_end, unit_end;

   assign cnt_inc    = {1'b0, cnt_q} + 1'b1;
   assign period_end = cnt_inc >= {1'b0, interval};
   assign unit_end   = unit_q >= units_last(freq);
   assign tick       = period_end && unit_end && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         unit_q <= '0;
      end else if (restart) begin
         cnt_q  <= '0;
         unit_q <= '0;
      end else if (period_end) begin
         cnt_q  <= '0;
         unit_q <= unit_end ? 4'd0 : unit_q + 4'd1;
      end else begin
         cnt_q  <= cnt_inc[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
   parameter int BACKLOG_W = 16,
   parameter int LIMIT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               tick,
   input  logic               ack,
   input  logic [LIMIT_W-1:0] limit,
   input  logic               err_clr,
   output logic               req,
   output logic               late_err
);

   localparam int                   CMP_W = (BACKLOG_W > LIMIT_W) ? BACKLOG_W : LIMIT_W;
   localparam logic [BACKLOG_W-1:0] FULL  = '1;

   logic [BACKLOG_W-1:0] owed_q;
   logic                 err_q, inc, dec, over;

   assign inc  = tick && (owed_q != FULL);
   assign dec  = ack && (owed_q != '0);
   assign over = CMP_W'(owed_q) > CMP_W'(limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owed_q <= '0;
      end else if (!enable) begin
         owed_q <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   owed_q <= owed_q + 1'b1;
            2'b01:   owed_q <= owed_q - 1'b1;
            default: owed_q <= owed_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= (err_q && !err_clr) || over;
   end

   assign req      = enable && (owed_q != '0);
   assign late_err = err_q;

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
   import sdram_refresh_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 16,
   parameter int LIMIT_W   = 16,
   parameter int BACKLOG_W = 16,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_BANKS-1:0] ref_ack,
   output logic [NUM_BANKS-1:0] ref_req,
   output logic [NUM_BANKS-1:0] bank_en,
   output logic [NUM_BANKS-1:0] bank_size,
   output logic [NUM_BANKS-1:0] man_pulse,
   output logic [NUM_BANKS-1:0] late_err
);

   generate
      if (DATA_W != 16)                     $error("DATA_W must be 16");
      if (ADDR_W < 3)                       $error("ADDR_W too small for the register map");
      if (CNT_W < 1 || CNT_W > DATA_W)      $error("CNT_W out of range");
      if (LIMIT_W < 1 || LIMIT_W > DATA_W)  $error("LIMIT_W out of range");
      if (BACKLOG_W < 2)                    $error("BACKLOG_W must be at least 2");
   endgenerate

   logic [1:0]           freq;
   logic [CNT_W-1:0]     interval;
   logic [LIMIT_W-1:0]   limit;
   logic                 restart, tick;
   logic [NUM_BANKS-1:0] err_clr;

   refresh_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .LIMIT_W(LIMIT_W), .RDATA_REG(RDATA_REG)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
      .err_flags(late_err), .rdata(bus_rdata), .enable(bank_en), .size(bank_size),
      .freq(freq), .interval(interval), .limit(limit), .restart(restart),
      .man_pulse(man_pulse), .err_clr(err_clr)
   );

   refresh_timer #(.CNT_W(CNT_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .restart(restart), .interval(interval),
      .freq(freq), .tick(tick)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         refresh_backlog #(.BACKLOG_W(BACKLOG_W), .LIMIT_W(LIMIT_W)) backlog_i (
            .clk(clk), .rst_n(rst_n), .enable(bank_en[b]), .tick(tick),
            .ack(ref_ack[b]), .limit(limit), .err_clr(err_clr[b]),
            .req(ref_req[b]), .late_err(late_err[b])
         );
      end
   endgenerate

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [1:0]        clr_bits,
   input logic [1:0]        ref_req,
   input logic [1:0]        ref_ack,
   input logic [1:0]        bank_en,
   input logic [1:0]        man_pulse,
   input logic [1:0]        late_err
);

   localparam logic [ADDR_W-1:0] A_CONF = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h06);

   for (genvar b = 0; b < 2; b++) begin : g_chk
      // R6
      req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ref_req[b] |-> bank_en[b]);

      // R7
      req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ref_req[b]) |-> ($past(ref_ack[b]) || !bank_en[b]));

      // R3
      man_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         man_pulse[b] |-> ($past(bus_we) && $past(bus_addr) == A_CONF && !bank_en[b]));

      // R10
      err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (late_err[b] && !(bus_we && bus_addr == A_STAT && clr_bits[b])) |=> late_err[b]);
   end

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .clr_bits(bus_wdata[1:0]), .ref_req(ref_req), .ref_ack(ref_ack),
   .bank_en(bank_en), .man_pulse(man_pulse), .late_err(late_err)
);

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  addr;
   logic        we;
   logic [15:0] wdata;
   logic [15:0] rdata;
   logic [1:0]  ack, req, en, size, man, err;
   int          total = 0;
   int          bad   = 0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   sdram_refresh_sched #(.BACKLOG_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rdata), .ref_ack(ack), .ref_req(req), .bank_en(en),
      .bank_size(size), .man_pulse(man), .late_err(err)
   );

   // {write, offset, write data, expected read}
   localparam int NV = 8;
   localparam logic [40:0] VEC [NV] = '{
      {1'b0, 8'h00, 16'h0000, 16'h0000},
      {1'b0, 8'h02, 16'h0000, 16'h0400},
      {1'b0, 8'h04, 16'h0000, 16'h0200},
      {1'b0, 8'h06, 16'h0000, 16'h0000},
      {1'b1, 8'h00, 16'hFF30, 16'h0030},
      {1'b1, 8'h02, 16'h1234, 16'h1234},
      {1'b1, 8'h04, 16'h00AB, 16'h00AB},
      {1'b1, 8'h00, 16'h00FC, 16'h00F0}
   };
   string vtag [NV];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // every task starts and ends on a falling edge
   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      addr = a;
      @(negedge clk);
      d = rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [15:0] got;
      vtag = '{"R1", "R1", "R1", "R1", "R2", "R4", "R4", "R2"};
      rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; ack = '0;
      wait_cyc(3);
      rst_n = 1'b1;
      chk("R1 req", req, 2'b00);
      chk("R1 err", err, 2'b00);
      chk("R1 man", man, 2'b00);
      chk("R1 en", en, 2'b00);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:16]);
         rd(VEC[i][39:32], got);
         chk(vtag[i], got, VEC[i][15:0]);
      end
      chk("R2 size", size, 2'b11);

      // R3: manual strobes
      wr(8'h00, 16'h000C);
      chk("R3 pulse", man, 2'b11);
      wait_cyc(1);
      chk("R3 one cycle", man, 2'b00);
      wr(8'h00, 16'h0005);
      chk("R3 enabled no pulse", man, 2'b00);
      wr(8'h00, 16'h0000);

      // R5/R6/R7/R10: interval 3, code 10 -> 12 cycles per obligation
      wr(8'h04, 16'h0002);
      wr(8'h00, 16'h0081);
      wr(8'h02, 16'h0003);          // write edge W, now at W+0.5
      wait_cyc(11);
      chk("R5 before due", req, 2'b00);
      wait_cyc(1);
      chk("R6 req at W+12", req, 2'b01);
      ack = 2'b01;
      wait_cyc(1);
      chk("R7 drop after ack", req, 2'b00);
      wait_cyc(1);                  // ack on empty backlog at edge W+14
      ack = 2'b00;
      chk("R7 empty ack ignored", req, 2'b00);
      wait_cyc(34);                 // W+48.5, backlog 3 since W+48
      chk("R10 not yet", err, 2'b00);
      wait_cyc(1);
      chk("R10 set", err, 2'b01);
      ack = 2'b01;
      wait_cyc(3);
      ack = 2'b00;
      chk("R7 drained", req, 2'b00);
      chk("R10 sticky", err, 2'b01);
      rd(8'h06, got);
      chk("R10 status read", got, 16'h0001);
      wr(8'h06, 16'h0001);
      chk("R10 cleared", err, 2'b00);

      // R8: 20 obligations into a 4-bit backlog
      wr(8'h04, 16'hFFFF);
      wr(8'h02, 16'h0001);
      wait_cyc(80);
      wr(8'h02, 16'hFFFF);
      ack = 2'b01;
      wait_cyc(14);
      chk("R8 still owed", req[0], 1'b1);
      wait_cyc(1);
      ack = 2'b00;
      chk("R8 empty after 15", req[0], 1'b0);

      // R6/R9: both banks, then disable A
      wr(8'h00, 16'h0083);
      wr(8'h02, 16'h0001);
      wait_cyc(8);
      chk("R6 both banks", req, 2'b11);
      wr(8'h02, 16'hFFFF);
      wr(8'h00, 16'h0082);
      chk("R9 disabled drop", req, 2'b10);
      wr(8'h00, 16'h0083);
      chk("R9 backlog cleared", req, 2'b10);

      // R5: code 00, interval 2 -> 32 cycles
      wr(8'h00, 16'h0000);
      wr(8'h00, 16'h0001);
      wr(8'h02, 16'h0002);
      wait_cyc(31);
      chk("R5 div16 before", req[0], 1'b0);
      wait_cyc(1);
      chk("R5 div16 due", req[0], 1'b1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule